// File: doc/BRIEF.md
# Non-Temporal Locality Hint Tagger

This block sits in the decode stage of an in-order pipeline that accepts one instruction word per cycle. It recognises the four no-op ADD forms, in 32-bit and in 16-bit encodings, that tell the memory system the next instruction's data has little temporal reuse. It then carries the chosen cache level for exactly one instruction. When that next instruction is a memory access that may carry the hint, the block emits a 2-bit level plus a valid flag beside it. This sideband tag is meant for the cache and allocation logic further down the pipeline. The hint words themselves are passed on marked as hints and act as discarded writes to register zero. The block changes no architectural state.

The block is a two-state machine. In S_IDLE no hint is pending. In S_ARMED a level is held in a register. The transitions are named below.
- T_ARM (S_IDLE to S_ARMED): a valid, non-trapping hint word is seen.
- T_REARM (S_ARMED to S_ARMED): a newer hint word replaces the held level.
- T_HOLD (S_ARMED to S_ARMED): an empty slot, with no valid instruction, keeps the level.
- T_CONSUME (S_ARMED to S_IDLE): any other valid instruction uses the hint up, whether or not that instruction is tagged.
- T_TRAP (S_ARMED to S_IDLE): the target instruction traps.
- T_KILL (either state to S_IDLE): a flush or a taken interrupt arrives.

S_IDLE stays in S_IDLE on every other input. Every output is registered, so results appear one cycle after the instruction is presented.

Top module: `locality_hint_tagger`

## Requirements
- R1: While reset is asserted and after its release, out_valid, out_hint, out_tag_valid and out_tag_level are all zero and no hint is pending.
- R2: A 32-bit word is a hint when its opcode is 0110011, funct3 is 000, funct7 is 0000000, rd is 0, rs1 is 0 and rs2 is 2 to 5. The held level is rs2-2, so 2 gives 00 (innermost private cache), 3 gives 01 (all private levels), 4 gives 10 (innermost shared level) and 5 gives 11 (all levels). One cycle later, out_hint is 1 and out_tag_valid is 0.
- R3: A 16-bit word, meaning bits [1:0] are not 11, is a hint when bits [15:12] are 1001, bits [11:7] are 0, bits [1:0] are 10 and bits [6:2] (rs2) are 2 to 5. The level is rs2-2, as in R2. Bits [31:16] are ignored for a 16-bit word.
- R4: When a hint is pending, the next valid instruction that is a taggable memory access produces out_valid=1, out_tag_valid=1 and out_tag_level equal to the held level, one cycle after it is presented. Taggable accesses are:
  - 32-bit loads and stores, opcodes 0000011, 0100011, 0000111 and 0100111;
  - atomics, opcode 0101111;
  - 16-bit loads and stores, quadrants 00 and 10 with funct3 of 001, 010, 011, 101, 110 or 111.
- R5: A hint applies to one instruction only. The instruction after the target is never tagged. A non-memory instruction, such as an ADD with rd not equal to 0, uses up the pending hint without being tagged.
- R6: A hint that immediately follows a pending hint replaces it, and the later level is the one applied.
- R7: The clean, flush and invalidate cache-management words use up the hint and are not tagged. These are opcode 0001111 with funct3 010 and an immediate of 1, 2 or 0. The zero operation (the same form with immediate 4) and the prefetches (opcode 0010011, funct3 110, rd 0, bits [24:20] equal to 0, 1 or 3) are tagged.
- R8: With cfg_skip_resv=1, load-reserved and store-conditional are untagged but still use up the hint. These are the atomics with bits [31:27] equal to 00010 or 00011. With cfg_skip_resv=0 they are tagged. Other atomics are tagged under either setting.
- R9: An instruction presented with in_trap=1 is passed on with out_valid=1 and is never tagged, and it discards any pending hint.
- R10: in_flush or in_irq discards the pending hint and suppresses out_valid for the instruction presented in that cycle.
- R11: Cycles with in_valid=0 give out_valid=0 and leave a pending hint and its level unchanged.
- R12: Near-miss ADD forms are not hints and leave nothing pending. These are rd not 0, rs1 not 0, funct7 not 0, funct3 not 000, and rs2 outside 2 to 5 (including the canonical no-op with rs2=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction word is presented this cycle |
| in_instr | input | 32 | Instruction word; a 16-bit form uses bits [15:0] |
| in_trap | input | 1 | The presented instruction takes a trap |
| in_flush | input | 1 | Pipeline flush; kills the presented instruction |
| in_irq | input | 1 | Interrupt taken before the presented instruction |
| cfg_skip_resv | input | 1 | 1: do not tag load-reserved or store-conditional |
| out_valid | output | 1 | Registered: instruction passed on |
| out_hint | output | 1 | Registered: the passed instruction is a hint word |
| out_tag_valid | output | 1 | Registered: the passed instruction carries a hint tag |
| out_tag_level | output | 2 | Registered: tag level, 00, 01, 10 or 11 |

## Verification
Some properties are checked on every cycle, from the ports and the state register:
- a tag never appears on two outputs in a row;
- a hint word is never tagged itself;
- a tag only rides on a valid output;
- a flush or interrupt clears the state and hides the next output;
- a trap disarms the machine;
- an empty slot keeps the held level.

Other behaviour can only be shown by the bench's scenarios:
- the exact bit patterns that count as hints in each encoding;
- the level mapping;
- which access classes are taggable, including the effect of the reservation setting;
- replacement by a newer hint;
- expiry after a non-memory instruction.

The bench sweeps every rs2 value in both hint encodings.

// File: rtl/lht_pkg.sv
package lht_pkg;

    localparam int INSTR_W       = 32;
    localparam int HALF_W        = 16;
    localparam int REG_W         = 5;
    localparam int NUM_LEVELS    = 4;
    localparam int LEVEL_W       = $clog2(NUM_LEVELS);
    localparam int HINT_REG_BASE = 2;

    localparam logic [6:0] OPC_LOAD     = 7'b0000011;
    localparam logic [6:0] OPC_LOAD_FP  = 7'b0000111;
    localparam logic [6:0] OPC_STORE    = 7'b0100011;
    localparam logic [6:0] OPC_STORE_FP = 7'b0100111;
    localparam logic [6:0] OPC_AMO      = 7'b0101111;
    localparam logic [6:0] OPC_MISC_MEM = 7'b0001111;
    localparam logic [6:0] OPC_OP_IMM   = 7'b0010011;
    localparam logic [6:0] OPC_OP       = 7'b0110011;

    localparam logic [4:0] AMO_F5_LR = 5'b00010;
    localparam logic [4:0] AMO_F5_SC = 5'b00011;

    typedef enum logic [LEVEL_W-1:0] {
        LVL_P1   = 2'd0,
        LVL_PALL = 2'd1,
        LVL_S1   = 2'd2,
        LVL_ALL  = 2'd3
    } hint_level_e;

    typedef enum logic [1:0] {
        MEM_NONE,
        MEM_PLAIN,
        MEM_RESV,
        MEM_CMO_EXCL
    } mem_kind_e;

    typedef enum logic {
        S_IDLE,
        S_ARMED
    } tag_state_e;

    typedef struct packed {
        logic        is_hint;
        hint_level_e level;
        mem_kind_e   kind;
    } dec_info_t;

endpackage

// File: rtl/lht_decode.sv
module lht_decode
    import lht_pkg::*;
#(
    parameter bit COMPRESSED = 1'b1
) (
    input  logic [INSTR_W-1:0] instr,
    output dec_info_t          info
);

    localparam logic [REG_W-1:0] REG_LO = REG_W'(HINT_REG_BASE);
    localparam logic [REG_W-1:0] REG_HI = REG_W'(HINT_REG_BASE + NUM_LEVELS - 1);

    function automatic logic in_hint_range(input logic [REG_W-1:0] r);
        return (r >= REG_LO) && (r <= REG_HI);
    endfunction

    function automatic hint_level_e level_of(input logic [REG_W-1:0] r);
        logic [REG_W-1:0] off;
        off = r - REG_LO;
        return hint_level_e'(off[LEVEL_W-1:0]);
    endfunction

    function automatic dec_info_t decode_wide(input logic [INSTR_W-1:0] w);
        dec_info_t d;
        logic [6:0] op;
        logic [2:0] f3;
        logic [6:0] f7;
        logic [4:0] rd;
        logic [4:0] rs1;
        logic [4:0] rs2;
        op  = w[6:0];
        rd  = w[11:7];
        f3  = w[14:12];
        rs1 = w[19:15];
        rs2 = w[24:20];
        f7  = w[31:25];
        d.is_hint = 1'b0;
        d.level   = LVL_P1;
        d.kind    = MEM_NONE;
        case (op)
            OPC_LOAD, OPC_LOAD_FP, OPC_STORE, OPC_STORE_FP: begin
                d.kind = MEM_PLAIN;
            end
            OPC_AMO: begin
                if (f3 == 3'b010 || f3 == 3'b011) begin
                    if (f7[6:2] == AMO_F5_LR || f7[6:2] == AMO_F5_SC)
                        d.kind = MEM_RESV;
                    else
                        d.kind = MEM_PLAIN;
                end
            end
            OPC_MISC_MEM: begin
                if (f3 == 3'b010) begin
                    case ({f7, rs2})
                        12'd0, 12'd1, 12'd2: d.kind = MEM_CMO_EXCL;
                        12'd4:               d.kind = MEM_PLAIN;
                        default:             d.kind = MEM_NONE;
                    endcase
                end
            end
            OPC_OP_IMM: begin
                if (f3 == 3'b110 && rd == 5'd0 &&
                    (rs2 == 5'd0 || rs2 == 5'd1 || rs2 == 5'd3))
                    d.kind = MEM_PLAIN;
            end
            OPC_OP: begin
                if (f3 == 3'b000 && f7 == 7'd0 && rd == 5'd0 &&
                    rs1 == 5'd0 && in_hint_range(rs2)) begin
                    d.is_hint = 1'b1;
                    d.level   = level_of(rs2);
                end
            end
            default: d.kind = MEM_NONE;
        endcase
        return d;
    endfunction

    function automatic dec_info_t decode_narrow(input logic [HALF_W-1:0] h);
        dec_info_t d;
        logic [1:0] q;
        logic [2:0] f3;
        logic       mem_f3;
        q  = h[1:0];
        f3 = h[15:13];
        mem_f3 = (f3 != 3'b000) && (f3 != 3'b100);
        d.is_hint = 1'b0;
        d.level   = LVL_P1;
        d.kind    = MEM_NONE;
        case (q)
            2'b00: begin
                if (mem_f3) d.kind = MEM_PLAIN;
            end
            2'b10: begin
                if (mem_f3) begin
                    d.kind = MEM_PLAIN;
                end else if (f3 == 3'b100 && h[12] && h[11:7] == 5'd0 &&
                             in_hint_range(h[6:2])) begin
                    d.is_hint = 1'b1;
                    d.level   = level_of(h[6:2]);
                end
            end
            default: d.kind = MEM_NONE;
        endcase
        return d;
    endfunction

    dec_info_t wide_info;
    dec_info_t narrow_info;
    logic      is_wide;

    assign is_wide   = (instr[1:0] == 2'b11);
    assign wide_info = decode_wide(instr);

    generate
        if (COMPRESSED) begin : g_narrow
            assign narrow_info = decode_narrow(instr[HALF_W-1:0]);
        end else begin : g_no_narrow
            assign narrow_info = '0;
        end
    endgenerate

    assign info = is_wide ? wide_info : narrow_info;

endmodule

// File: rtl/lht_policy.sv
module lht_policy
    import lht_pkg::*;
(
    input  mem_kind_e kind,
    input  logic      skip_resv,
    output logic      taggable
);

    always_comb begin
        unique case (kind)
            MEM_PLAIN:    taggable = 1'b1;
            MEM_RESV:     taggable = !skip_resv;
            MEM_CMO_EXCL: taggable = 1'b0;
            MEM_NONE:     taggable = 1'b0;
            default:      taggable = 1'b0;
        endcase
    end

endmodule

// File: rtl/lht_fsm.sv
module lht_fsm
    import lht_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_trap,
    input  logic        kill,
    input  dec_info_t   info,
    input  logic        taggable,
    output tag_state_e  state,
    output logic        tag_fire,
    output hint_level_e tag_level
);

    tag_state_e  state_nx;
    hint_level_e pend_q;
    hint_level_e pend_nx;
    logic        live;

    assign live = in_valid && !kill;

    always_comb begin
        state_nx = state;
        pend_nx  = pend_q;
        unique case (state)
            S_IDLE: begin
                if (live && !in_trap && info.is_hint) begin
                    state_nx = S_ARMED;
                    pend_nx  = info.level;
                end
            end
            S_ARMED: begin
                if (kill) begin
                    state_nx = S_IDLE;
                end else if (!in_valid) begin
                    state_nx = S_ARMED;
                end else if (in_trap) begin
                    state_nx = S_IDLE;
                end else if (info.is_hint) begin
                    state_nx = S_ARMED;
                    pend_nx  = info.level;
                end else begin
                    state_nx = S_IDLE;
                end
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            pend_q <= LVL_P1;
        end else begin
            state  <= state_nx;
            pend_q <= pend_nx;
        end
    end

    always_comb begin
        tag_fire  = 1'b0;
        tag_level = LVL_P1;
        unique case (state)
            S_ARMED: begin
                if (live && !in_trap && !info.is_hint && taggable) begin
                    tag_fire  = 1'b1;
                    tag_level = pend_q;
                end
            end
            S_IDLE:  tag_fire = 1'b0;
            default: tag_fire = 1'b0;
        endcase
    end

    // R10: kill always returns the machine to idle
    a_r10_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> state == S_IDLE);

    // R11: an empty slot keeps the held hint and level
    a_r11_bubble_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARMED && !in_valid && !kill) |=> (state == S_ARMED && $stable(pend_q)));

    // R9: a trapping instruction leaves nothing pending
    a_r9_trap_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_trap && !kill) |=> state == S_IDLE);

endmodule

// File: rtl/locality_hint_tagger.sv
module locality_hint_tagger
    import lht_pkg::*;
#(
    parameter bit COMPRESSED = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_instr,
    input  logic               in_trap,
    input  logic               in_flush,
    input  logic               in_irq,
    input  logic               cfg_skip_resv,
    output logic               out_valid,
    output logic               out_hint,
    output logic               out_tag_valid,
    output logic [LEVEL_W-1:0] out_tag_level
);

    dec_info_t   info;
    logic        taggable;
    logic        kill;
    tag_state_e  state;
    logic        tag_fire;
    hint_level_e tag_level;

    assign kill = in_flush || in_irq;

    lht_decode #(.COMPRESSED(COMPRESSED)) u_decode (
        .instr (in_instr),
        .info  (info)
    );

    lht_policy u_policy (
        .kind      (info.kind),
        .skip_resv (cfg_skip_resv),
        .taggable  (taggable)
    );

    lht_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_trap   (in_trap),
        .kill      (kill),
        .info      (info),
        .taggable  (taggable),
        .state     (state),
        .tag_fire  (tag_fire),
        .tag_level (tag_level)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_hint      <= 1'b0;
            out_tag_valid <= 1'b0;
            out_tag_level <= '0;
        end else begin
            out_valid     <= in_valid && !kill;
            out_hint      <= in_valid && !kill && info.is_hint;
            out_tag_valid <= tag_fire;
            out_tag_level <= tag_fire ? tag_level : LVL_P1;
        end
    end

    // R5: a hint is spent on a single instruction
    a_r5_single_use: assert property (@(posedge clk) disable iff (!rst_n)
        out_tag_valid |=> !out_tag_valid);

    // R2: a hint word never carries a tag itself
    a_r2_hint_untagged: assert property (@(posedge clk) disable iff (!rst_n)
        out_hint |-> !out_tag_valid);

    // R4: a tag only accompanies a passed instruction
    a_r4_tag_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_tag_valid |-> out_valid);

    // R10: a killed slot produces no output
    a_r10_kill_hides: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !out_valid);

    // R9: a trapping instruction is not tagged
    a_r9_trap_untagged: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_trap) |=> !out_tag_valid);

endmodule

// File: tb/locality_hint_tagger_bench.sv
module locality_hint_tagger_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = 32'd0;
    logic        in_trap = 1'b0;
    logic        in_flush = 1'b0;
    logic        in_irq = 1'b0;
    logic        cfg_skip_resv = 1'b0;
    logic        out_valid;
    logic        out_hint;
    logic        out_tag_valid;
    logic [1:0]  out_tag_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    locality_hint_tagger u_locality_hint_tagger (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_instr      (in_instr),
        .in_trap       (in_trap),
        .in_flush      (in_flush),
        .in_irq        (in_irq),
        .cfg_skip_resv (cfg_skip_resv),
        .out_valid     (out_valid),
        .out_hint      (out_hint),
        .out_tag_valid (out_tag_valid),
        .out_tag_level (out_tag_level)
    );

    function automatic logic [31:0] h32(input int r);
        return {7'd0, 5'(r), 5'd0, 3'b000, 5'd0, 7'b0110011};
    endfunction
    function automatic logic [31:0] h16(input int r);
        return {16'd0, 4'b1001, 5'd0, 5'(r), 2'b10};
    endfunction
    function automatic logic [31:0] amo(input logic [4:0] f5);
        return {f5, 2'b00, 5'd3, 5'd2, 3'b010, 5'd1, 7'b0101111};
    endfunction
    function automatic logic [31:0] cbo(input logic [11:0] imm);
        return {imm, 5'd2, 3'b010, 5'd0, 7'b0001111};
    endfunction
    function automatic logic [31:0] pref(input logic [4:0] k);
        return {7'd0, k, 5'd2, 3'b110, 5'd0, 7'b0010011};
    endfunction

    localparam logic [31:0] LW32   = {12'd0, 5'd1, 3'b010, 5'd6, 7'b0000011};
    localparam logic [31:0] SW32   = {7'd0, 5'd6, 5'd1, 3'b010, 5'd0, 7'b0100011};
    localparam logic [31:0] FLW32  = {12'd0, 5'd1, 3'b010, 5'd6, 7'b0000111};
    localparam logic [31:0] FSW32  = {7'd0, 5'd6, 5'd1, 3'b010, 5'd0, 7'b0100111};
    localparam logic [31:0] ADD32  = {7'd0, 5'd3, 5'd2, 3'b000, 5'd1, 7'b0110011};
    localparam logic [31:0] CLW    = {16'd0, 3'b010, 11'd0, 2'b00};
    localparam logic [31:0] CSW    = {16'd0, 3'b110, 11'd0, 2'b00};
    localparam logic [31:0] CLWSP  = {16'd0, 3'b010, 1'b0, 5'd1, 5'd0, 2'b10};
    localparam logic [31:0] CLI    = {16'd0, 3'b010, 1'b0, 5'd1, 5'd1, 2'b01};

    task automatic check(input string req, input string what,
                         input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] w, input logic v, input logic tr,
                        input logic fl, input logic iq,
                        input logic ev, input logic eh, input logic etv,
                        input logic [1:0] el, input string req);
        @(negedge clk);
        in_instr = w;
        in_valid = v;
        in_trap  = tr;
        in_flush = fl;
        in_irq   = iq;
        @(posedge clk);
        #1;
        check(req, "out {valid,hint,tag_valid,level}",
              {out_valid, out_hint, out_tag_valid, out_tag_level},
              {ev, eh, etv, el});
    endtask

    task automatic go(input logic [31:0] w, input logic etv, input logic [1:0] el,
                      input string req);
        step(w, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, etv, el, req);
    endtask

    task automatic hint(input logic [31:0] w, input string req);
        step(w, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1", "outputs in reset", {out_valid, out_hint, out_tag_valid, out_tag_level}, 5'd0);
        rst_n = 1'b1;
        step(32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, "R1");
        go(LW32, 1'b0, 2'd0, "R1");

        // R2 + R4 + R5: full rs2 sweep, 32-bit form, then a load and a second load
        for (int r = 0; r < 32; r++) begin
            logic is_h;
            is_h = (r >= 2 && r <= 5);
            step(h32(r), 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, is_h, 1'b0, 2'd0, "R2");
            go(LW32, is_h, is_h ? 2'(r - 2) : 2'd0, "R2");
            go(LW32, 1'b0, 2'd0, "R5");
        end

        // R3: full rs2 sweep, 16-bit form with junk in upper half, 16-bit load target
        for (int r = 0; r < 32; r++) begin
            logic is_h;
            is_h = (r >= 2 && r <= 5);
            step(h16(r) | 32'hA5A5_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, is_h, 1'b0, 2'd0, "R3");
            go(CLW, is_h, is_h ? 2'(r - 2) : 2'd0, "R3");
        end

        // R12: near-miss encodings
        step(h32(3) | (32'd1 << 7),  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, "R12");
        go(LW32, 1'b0, 2'd0, "R12");
        step(h32(3) | (32'd1 << 15), 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, "R12");
        go(LW32, 1'b0, 2'd0, "R12");
        step(h32(3) | (32'h20 << 25), 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, "R12");
        go(LW32, 1'b0, 2'd0, "R12");
        step(h32(3) | (32'd1 << 12), 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, "R12");
        go(LW32, 1'b0, 2'd0, "R12");
        step(h16(4) | (32'd1 << 7),  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, "R12");
        go(LW32, 1'b0, 2'd0, "R12");

        // R4 + R7: taggable classes, each with a distinct level
        for (int k = 0; k < 10; k++) begin
            logic [31:0] tgt;
            case (k)
                0: tgt = SW32;  1: tgt = FLW32; 2: tgt = FSW32;
                3: tgt = amo(5'b00000); 4: tgt = cbo(12'd4);
                5: tgt = pref(5'd0); 6: tgt = pref(5'd1); 7: tgt = pref(5'd3);
                8: tgt = CSW; default: tgt = CLWSP;
            endcase
            hint(h32(2 + (k % 4)), "R4");
            go(tgt, 1'b1, 2'(k % 4), (k >= 4 && k <= 7) ? "R7" : "R4");
        end

        // R7: excluded cache ops consume the hint and stay untagged
        for (int k = 0; k < 3; k++) begin
            hint(h32(5), "R7");
            go(cbo(12'(k)), 1'b0, 2'd0, "R7");
            go(LW32, 1'b0, 2'd0, "R7");
        end

        // R5: non-memory target consumes the hint (32-bit and 16-bit)
        hint(h32(4), "R5");
        go(ADD32, 1'b0, 2'd0, "R5");
        go(LW32, 1'b0, 2'd0, "R5");
        hint(h16(4), "R5");
        go(CLI, 1'b0, 2'd0, "R5");
        go(CLW, 1'b0, 2'd0, "R5");

        // R8: reservation pair under both settings, other atomic always tagged
        for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            cfg_skip_resv = c[0];
            hint(h32(3), "R8");
            go(amo(5'b00010), !c[0], c[0] ? 2'd0 : 2'd1, "R8");
            go(LW32, 1'b0, 2'd0, "R8");
            hint(h32(4), "R8");
            go(amo(5'b00011), !c[0], c[0] ? 2'd0 : 2'd2, "R8");
            hint(h32(5), "R8");
            go(amo(5'b00001), 1'b1, 2'd3, "R8");
        end
        cfg_skip_resv = 1'b0;

        // R6: replacement by a newer hint
        hint(h32(2), "R6");
        hint(h16(5), "R6");
        go(LW32, 1'b1, 2'd3, "R6");
        hint(h32(5), "R6");
        hint(h32(3), "R6");
        go(SW32, 1'b1, 2'd1, "R6");

        // R9: trapping target
        hint(h32(4), "R9");
        step(LW32, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, "R9");
        go(LW32, 1'b0, 2'd0, "R9");

        // R10: flush and interrupt drop the hint and hide the slot
        hint(h32(5), "R10");
        step(32'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, "R10");
        go(LW32, 1'b0, 2'd0, "R10");
        hint(h32(5), "R10");
        step(LW32, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, "R10");
        go(LW32, 1'b0, 2'd0, "R10");
        step(h32(2), 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, "R10");
        go(LW32, 1'b0, 2'd0, "R10");

        // R11: bubbles keep the hint
        hint(h32(4), "R11");
        for (int b = 0; b < 3; b++)
            step(LW32, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, "R11");
        go(LW32, 1'b1, 2'd2, "R11");
        go(LW32, 1'b0, 2'd0, "R11");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule